// File: doc/BRIEF.md
# Key-Guarded Reset Request Register

This block is a single 32-bit memory-mapped control word that lets software ask for a system reset, a core vector reset or a clear of active exception state. To guard against stray stores, a write has effect only when its upper half carries an unlock key. A keyed write can also load a three-bit priority-grouping field, which the block holds until the next keyed write or the next reset. A status bit shows the memory byte order. A board-level tie-off input fixes this bit, and no write can change it.

Software asks for a reset with a read-modify-write. It reads the word, keeps the grouping field, ORs in the key and the request bit, and writes the result back. Reads never return the key. They return a fixed key-status pattern in the upper half, and the request bits read as zero because each request lasts only one cycle.

Top module: `rstctl_keyreg`

## Requirements
- R1: The block responds only when `acc_sel` is high and `acc_addr` equals the `BASE_ADDR` parameter (default 8'h40). Any other access changes no state, raises no request, and returns `rd_data` = 0.
- R2: A write with `wr_data[31:16]` = 16'h05FA loads `wr_data[10:8]` into the grouping field. The new value is visible in the read-back from the next cycle.
- R3: A write whose `wr_data[31:16]` differs from 16'h05FA is ignored entirely. The grouping field keeps its value, and no request output rises.
- R4: A keyed write with `wr_data[2]` set drives `sys_rst_req` high for exactly the one cycle after the write's clock edge.
- R5: A keyed write with `wr_data[0]` set drives `vec_rst_req` high for exactly the one cycle after the write's clock edge.
- R6: A keyed write with `wr_data[1]` set drives `clr_act_req` high for exactly the one cycle after the write's clock edge.
- R7: A read (`acc_sel` = 1, `acc_we` = 0, address hit) returns the following fields: 16'hFA05 in bits 31:16, the byte-order bit in bit 15, the grouping field in bits 10:8, and zero in bits 14:11 and 7:0. Bits 2:0 in particular always read as zero.
- R8: Read bit 15 always equals the input `cfg_big_endian`, where 1 means big-endian. No write can change it.
- R9: While `rst_n` is low at a clock edge, the grouping field clears to 0 and all three request outputs go low.
- R10: One keyed write can load the grouping field and raise any mix of the three request outputs in the same cycle. Each of these effects happens as it would alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_sel | input | 1 | Access strobe, one cycle per access |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Word address of the access |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data, zero when not read |
| cfg_big_endian | input | 1 | Byte-order tie-off, 1 = big-endian |
| sys_rst_req | output | 1 | One-cycle system reset request |
| vec_rst_req | output | 1 | One-cycle core vector reset request |
| clr_act_req | output | 1 | One-cycle clear-active request |

## Verification
One keyed write can both load a new grouping value and raise a reset request. Both effects fall on the same clock edge, and the block must not let the request path win over the field path or the reverse. The bench provokes this with keyed writes that carry a new grouping value together with one, two or all three request bits. In the cycle after each write it compares every request output with the written bits, and a read in that same cycle must show the new grouping value. Writes with a wrong key or a wrong address that carry the same bit patterns must leave both the outputs and the read-back unchanged.

// File: rtl/rstctl_pkg.sv
// Package: shared constants for the key-guarded reset request register.
// Field positions are fixed by the software view of the word; the key
// values are the unlock pattern on writes and the status pattern on reads.
package rstctl_pkg;
    localparam int          DATA_W     = 32;
    localparam int          KEY_LSB    = 16;
    localparam int          KEY_W      = 16;
    localparam logic [15:0] WR_KEY     = 16'h05FA;
    localparam logic [15:0] RD_STATUS  = 16'hFA05;
    localparam int          GRP_LSB    = 8;
    localparam int          GRP_W      = 3;
    localparam int          ENDIAN_BIT = 15;
    localparam int          NUM_REQ    = 3;
    localparam int          VEC_BIT    = 0;
    localparam int          CLR_BIT    = 1;
    localparam int          SYS_BIT    = 2;
endpackage

// File: rtl/rstctl_decode.sv
// Module: rstctl_decode
// Decodes one access. It matches the word address against BASE_ADDR,
// classifies the access as a read or a write and, for writes, checks the
// key half of the data. Purely combinational; assumes the strobe and the
// address are stable around the clock edge.
module rstctl_decode
    import rstctl_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
    input  logic              acc_sel,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [KEY_W-1:0]  key_field,
    output logic              wr_ok,
    output logic              rd_hit
);
    logic addr_hit;

    // Address match and key check for the current access.
    always_comb begin
        addr_hit = acc_sel && (acc_addr == BASE_ADDR);
        wr_ok    = addr_hit && acc_we && (key_field == WR_KEY);
        rd_hit   = addr_hit && !acc_we;
    end
endmodule

// File: rtl/rstctl_group_reg.sv
// Module: rstctl_group_reg
// Holds the priority-grouping field. It loads only on a keyed write and
// clears on synchronous reset. Assumes `load` is already qualified.
module rstctl_group_reg
    import rstctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GRP_W-1:0] grp_in,
    output logic [GRP_W-1:0] grp_q
);
    // Field storage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)    grp_q <= '0;
        else if (load) grp_q <= grp_in;
    end
endmodule

// File: rtl/rstctl_req_pulse.sv
// Module: rstctl_req_pulse
// One flop per request bit. Each output is high for the single cycle
// after a keyed write that sets its bit, so the requests clear themselves.
// Assumes the `fire` input is already qualified by the key check.
module rstctl_req_pulse
    import rstctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  logic [NUM_REQ-1:0] req_bits,
    output logic [NUM_REQ-1:0] req_pulse
);
    for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
        // Registers one request bit; it drops again on the next edge.
        always_ff @(posedge clk) begin
            if (!rst_n) req_pulse[i] <= 1'b0;
            else        req_pulse[i] <= fire && req_bits[i];
        end
    end
endmodule

// File: rtl/rstctl_rd_mux.sv
// Module: rstctl_rd_mux
// Builds the read word: the status pattern, the byte-order bit and the
// grouping field; every other bit is zero. Output is zero when the
// access is not a read hit, so it can be ORed onto a shared read bus.
module rstctl_rd_mux
    import rstctl_pkg::*;
(
    input  logic              rd_hit,
    input  logic [GRP_W-1:0]  grp_q,
    input  logic              big_endian,
    output logic [DATA_W-1:0] rd_data
);
    // Assemble the read word from its fields.
    always_comb begin
        rd_data = '0;
        if (rd_hit) begin
            rd_data[KEY_LSB +: KEY_W] = RD_STATUS;
            rd_data[ENDIAN_BIT]       = big_endian;
            rd_data[GRP_LSB +: GRP_W] = grp_q;
        end
    end
endmodule

// File: rtl/rstctl_keyreg.sv
// Module: rstctl_keyreg (top)
// Key-guarded reset request register. Address decode and key check feed
// the grouping-field register and the request pulse flops; reads use a
// combinational mux. Assumes a single-cycle access strobe, a synchronous
// active-low reset and a static byte-order tie-off.
module rstctl_keyreg
    import rstctl_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_sel,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    input  logic              cfg_big_endian,
    output logic              sys_rst_req,
    output logic              vec_rst_req,
    output logic              clr_act_req
);
    logic               wr_ok;
    logic               rd_hit;
    logic [GRP_W-1:0]   grp_q;
    logic [NUM_REQ-1:0] req_pulse;

    rstctl_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
        .acc_sel   (acc_sel),
        .acc_we    (acc_we),
        .acc_addr  (acc_addr),
        .key_field (wr_data[KEY_LSB +: KEY_W]),
        .wr_ok     (wr_ok),
        .rd_hit    (rd_hit)
    );

    rstctl_group_reg u_group (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (wr_ok),
        .grp_in (wr_data[GRP_LSB +: GRP_W]),
        .grp_q  (grp_q)
    );

    rstctl_req_pulse u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (wr_ok),
        .req_bits  (wr_data[NUM_REQ-1:0]),
        .req_pulse (req_pulse)
    );

    rstctl_rd_mux u_rd (
        .rd_hit     (rd_hit),
        .grp_q      (grp_q),
        .big_endian (cfg_big_endian),
        .rd_data    (rd_data)
    );

    // Map the request vector onto the named outputs.
    always_comb begin
        sys_rst_req = req_pulse[SYS_BIT];
        vec_rst_req = req_pulse[VEC_BIT];
        clr_act_req = req_pulse[CLR_BIT];
    end
endmodule

// File: rtl/rstctl_keyreg_chk.sv
// Module: rstctl_keyreg_chk
// Property checker for rstctl_keyreg, attached by bind. It sees the ports
// and the stored grouping field, and it forms its own decode of the key and
// address from the port values.
module rstctl_keyreg_chk
    import rstctl_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_sel,
    input logic              acc_we,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [31:0]       wr_data,
    input logic [31:0]       rd_data,
    input logic              cfg_big_endian,
    input logic              sys_rst_req,
    input logic              vec_rst_req,
    input logic              clr_act_req,
    input logic [GRP_W-1:0]  grp_q
);
    logic hit_c, keyed_c, bad_c, rd_c;
    always_comb begin
        hit_c   = acc_sel && (acc_addr == BASE_ADDR);
        keyed_c = hit_c && acc_we && (wr_data[31:16] == 16'h05FA);
        bad_c   = acc_sel && acc_we && !keyed_c;
        rd_c    = hit_c && !acc_we;
    end

    AST_NOHIT_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel && (acc_addr != BASE_ADDR)) |-> (rd_data == 32'h0)); // R1
    AST_KEYED_LOADS_GRP: assert property (@(posedge clk) disable iff (!rst_n)
        keyed_c |=> (grp_q == $past(wr_data[10:8]))); // R2
    AST_BADKEY_GRP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        bad_c |=> $stable(grp_q)); // R3
    AST_BADKEY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        bad_c |=> !(sys_rst_req || vec_rst_req || clr_act_req)); // R3
    AST_SYS_FROM_KEYED: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> $past(keyed_c && wr_data[2])); // R4
    AST_VEC_FROM_KEYED: assert property (@(posedge clk) disable iff (!rst_n)
        vec_rst_req |-> $past(keyed_c && wr_data[0])); // R5
    AST_CLR_FROM_KEYED: assert property (@(posedge clk) disable iff (!rst_n)
        clr_act_req |-> $past(keyed_c && wr_data[1])); // R6
    AST_RD_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_c |-> (rd_data[31:16] == 16'hFA05 && rd_data[2:0] == 3'b000
                  && rd_data[10:8] == grp_q)); // R7
    AST_RD_ENDIAN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_c |-> (rd_data[15] == cfg_big_endian)); // R8
endmodule

bind rstctl_keyreg rstctl_keyreg_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .acc_sel        (acc_sel),
    .acc_we         (acc_we),
    .acc_addr       (acc_addr),
    .wr_data        (wr_data),
    .rd_data        (rd_data),
    .cfg_big_endian (cfg_big_endian),
    .sys_rst_req    (sys_rst_req),
    .vec_rst_req    (vec_rst_req),
    .clr_act_req    (clr_act_req),
    .grp_q          (grp_q)
);

// File: tb/rstctl_keyreg_tb.sv
// Bench for rstctl_keyreg. Inputs change on the falling edge; outputs are
// sampled on the falling edge after the rising edge that registers them.
module rstctl_keyreg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_sel = 1'b0;
    logic        acc_we = 1'b0;
    logic [7:0]  acc_addr = 8'h00;
    logic [31:0] wr_data = 32'h0;
    logic [31:0] rd_data;
    logic        cfg_big_endian = 1'b1;
    logic        sys_rst_req, vec_rst_req, clr_act_req;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    rstctl_keyreg #(.ADDR_W(8), .BASE_ADDR(8'h40)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_sel(acc_sel), .acc_we(acc_we),
        .acc_addr(acc_addr), .wr_data(wr_data), .rd_data(rd_data),
        .cfg_big_endian(cfg_big_endian), .sys_rst_req(sys_rst_req),
        .vec_rst_req(vec_rst_req), .clr_act_req(clr_act_req)
    );

    // Vector: {addr[8], wdata[32], pulses {sys,clr,vec}[3], read-back[32]}
    localparam int NVEC = 10;
    localparam logic [74:0] VEC [NVEC] = '{
        {8'h40, 32'h05FA_0300, 3'b000, 32'hFA05_8300},  // R2 load grp 3
        {8'h40, 32'h05FA_0504, 3'b100, 32'hFA05_8500},  // R4 R10 sys + grp 5
        {8'h40, 32'h1234_0704, 3'b000, 32'hFA05_8500},  // R3 bad key
        {8'h40, 32'h05FA_0101, 3'b001, 32'hFA05_8100},  // R5 vec + grp 1
        {8'h40, 32'h05FA_0102, 3'b010, 32'hFA05_8100},  // R6 clr
        {8'h44, 32'h05FA_0604, 3'b000, 32'hFA05_8100},  // R1 wrong address
        {8'h40, 32'hFA05_0007, 3'b000, 32'hFA05_8100},  // R3 status pattern is not a key
        {8'h40, 32'h05FA_8707, 3'b111, 32'hFA05_8700},  // R10 all requests + grp 7
        {8'h40, 32'h05FA_7800, 3'b000, 32'hFA05_8000},  // R7 reserved bits not stored
        {8'h40, 32'h05FA_0605, 3'b101, 32'hFA05_8600}   // R10 sys+vec + grp 6
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pulses();
        return {29'h0, sys_rst_req, clr_act_req, vec_rst_req};
    endfunction

    // One write: after return we are on the falling edge following the capture edge.
    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        acc_sel = 1'b1; acc_we = 1'b1; acc_addr = a; wr_data = d;
        @(negedge clk);
        acc_sel = 1'b0; acc_we = 1'b0; wr_data = 32'h0;
    endtask

    // Combinational read in the current low phase.
    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        acc_sel = 1'b1; acc_we = 1'b0; acc_addr = a;
        #1 d = rd_data;
        @(negedge clk);
        acc_sel = 1'b0;
    endtask

    initial begin : watchdog
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check("R9 pulses after reset", pulses(), 32'h0);
        do_read(8'h40, rd);
        check("R9 read after reset", rd, 32'hFA05_8000);

        for (int i = 0; i < NVEC; i++) begin
            do_write(VEC[i][74:67], VEC[i][66:35]);
            check($sformatf("R4/R5/R6 pulses vec %0d", i), pulses(), {29'h0, VEC[i][34:32]});
            do_read(8'h40, rd);
            check($sformatf("R4 pulse cleared vec %0d", i), pulses(), 32'h0);
            check($sformatf("R2/R3 read-back vec %0d", i), rd, VEC[i][31:0]);
        end

        // R1 read at another address returns zero
        do_read(8'h3C, rd);
        check("R1 non-hit read", rd, 32'h0);

        // R1 write while not selected has no effect
        @(negedge clk);
        acc_sel = 1'b0; acc_we = 1'b1; acc_addr = 8'h40; wr_data = 32'h05FA_0104;
        @(negedge clk);
        acc_we = 1'b0;
        check("R1 unselected write no pulse", pulses(), 32'h0);
        do_read(8'h40, rd);
        check("R1 unselected write no load", rd, 32'hFA05_8600);

        // R8 byte-order tie-off, keyed write with bit 15 clear cannot alter it
        cfg_big_endian = 1'b0;
        do_write(8'h40, 32'h05FA_0200);
        do_read(8'h40, rd);
        check("R8 little-endian read", rd, 32'hFA05_0200);
        do_write(8'h40, 32'h05FA_8200);
        do_read(8'h40, rd);
        check("R8 write of bit15 ignored", rd, 32'hFA05_0200);
        cfg_big_endian = 1'b1;

        // R10 read in the pulse cycle shows the new group
        do_write(8'h40, 32'h05FA_0404);
        acc_sel = 1'b1; acc_we = 1'b0; acc_addr = 8'h40;
        #1;
        check("R10 pulse with new group", pulses(), 32'h4);
        check("R10 read in pulse cycle", rd_data, 32'hFA05_8400);
        @(negedge clk);
        acc_sel = 1'b0;

        // R9 reset clears the group and cancels a pending pulse
        @(negedge clk);
        acc_sel = 1'b1; acc_we = 1'b1; acc_addr = 8'h40; wr_data = 32'h05FA_0707;
        rst_n = 1'b0;
        @(negedge clk);
        acc_sel = 1'b0; acc_we = 1'b0;
        check("R9 no pulse under reset", pulses(), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        do_read(8'h40, rd);
        check("R9 group cleared", rd, 32'hFA05_8000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule